// File: doc/BRIEF.md
# Low-Power Request Filter

This block sits on the receive side of a PCIe function. It classifies each incoming transaction header by type while the function may be in the D3hot power state. In D3hot the function only serves configuration and message traffic. Other requests are rejected as unsupported, and completions can be flagged as unexpected when a configuration input selects this. Outside D3hot every header is accepted.

When an unsupported request arrives in D3hot and error reporting is enabled, the block asks the link logic to bring the link back to L0 if it is not there already. It also raises a request to the message logic to send an error message. That request is held pending and is shown only while the link reports L0. It stays up until the message logic acknowledges it.

The classification result is registered and appears one clock after the header strobe. Type codes on `hdr_kind` are: 0 memory read, 1 memory write, 2 I/O, 3 configuration, 4 message, 5 completion, 6 and 7 other requests.

Top module: `lp_req_filter`

## Requirements
- R1: In D3hot, a header of kind 3 (configuration) or 4 (message) produces `accept` high for one cycle, one clock after `hdr_vld`, with both error flags low.
- R2: In D3hot, a header of kind 0, 1, 2, 6 or 7 produces `unsup_req` high for one cycle, one clock after `hdr_vld`, with `accept` low.
- R3: In D3hot, a header of kind 5 (completion) produces `unexp_cpl` one clock later when `cpl_chk_en` is 1, and produces `accept` when `cpl_chk_en` is 0.
- R4: Outside D3hot, every header kind produces `accept` one clock later and no error flag.
- R5: An unsupported request with `err_rpt_en` high, seen while `link_in_l0` is low, raises `l0_req` from the next cycle. `l0_req` stays high until a clock edge samples `link_in_l0` high, and then drops. If the link is already in L0, `l0_req` stays low.
- R6: An unsupported request with `err_rpt_en` high leaves an error message pending from the next cycle. `err_msg_req` is high while the message is pending and `link_in_l0` is high. The pending message clears after a clock edge at which `msg_ack` and `err_msg_req` are both high, unless a new error arrives at that same edge.
- R7: With `err_rpt_en` low, an unsupported request is still flagged but raises neither `l0_req` nor a pending message.
- R8: In a cycle after one with `hdr_vld` low, `accept`, `unsup_req` and `unexp_cpl` are all low.
- R9: During reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_vld | input | 1 | Header present this cycle |
| hdr_kind | input | 3 | Transaction type code |
| in_d3hot | input | 1 | Function is in D3hot |
| err_rpt_en | input | 1 | Error reporting enabled |
| cpl_chk_en | input | 1 | Flag completions received in D3hot as unexpected |
| link_in_l0 | input | 1 | Link currently in L0 |
| msg_ack | input | 1 | Message logic has taken the error message |
| accept | output | 1 | Header accepted (one-cycle pulse) |
| unsup_req | output | 1 | Unsupported request detected (pulse) |
| unexp_cpl | output | 1 | Unexpected completion detected (pulse) |
| l0_req | output | 1 | Request to return the link to L0 |
| err_msg_req | output | 1 | Request to send an error message |

## Verification
The assertions assume that `hdr_kind` holds a known code whenever `hdr_vld` is high. They also assume that all inputs change only between clock edges, and that `msg_ack` has no meaning unless `err_msg_req` is high. The stimulus changes every input one nanosecond after the rising edge, so each input holds a single value across the whole sampling window. The random phase draws `msg_ack` freely, which also tests acknowledges given while nothing is pending. `link_in_l0` is toggled at random, so both the L0-request hold and the message gating are exercised.

// File: rtl/lp_req_filter.sv
module lp_req_filter #(
  parameter int KIND_W = 3,
  parameter logic [KIND_W-1:0] KIND_CFG = 3'd3,
  parameter logic [KIND_W-1:0] KIND_MSG = 3'd4,
  parameter logic [KIND_W-1:0] KIND_CPL = 3'd5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_vld,
  input  logic [KIND_W-1:0] hdr_kind,
  input  logic              in_d3hot,
  input  logic              err_rpt_en,
  input  logic              cpl_chk_en,
  input  logic              link_in_l0,
  input  logic              msg_ack,
  output logic              accept,
  output logic              unsup_req,
  output logic              unexp_cpl,
  output logic              l0_req,
  output logic              err_msg_req
);

  logic is_allowed, is_cpl, ur_now, uc_now, err_evt, msg_pend;

  assign is_allowed = (hdr_kind == KIND_CFG) || (hdr_kind == KIND_MSG);
  assign is_cpl     = (hdr_kind == KIND_CPL);
  assign ur_now     = hdr_vld && in_d3hot && !is_allowed && !is_cpl;
  assign uc_now     = hdr_vld && in_d3hot && is_cpl && cpl_chk_en;
  assign err_evt    = ur_now && err_rpt_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accept    <= 1'b0;
      unsup_req <= 1'b0;
      unexp_cpl <= 1'b0;
    end else begin
      accept    <= hdr_vld && !ur_now && !uc_now;
      unsup_req <= ur_now;
      unexp_cpl <= uc_now;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     l0_req <= 1'b0;
    else if (err_evt && !link_in_l0) l0_req <= 1'b1;
    else if (link_in_l0)            l0_req <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        msg_pend <= 1'b0;
    else if (err_evt)                  msg_pend <= 1'b1;
    else if (err_msg_req && msg_ack)   msg_pend <= 1'b0;
  end

  assign err_msg_req = msg_pend && link_in_l0;

  // R1
  d3_allowed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hdr_vld) && $past(in_d3hot) && ($past(hdr_kind) == KIND_CFG || $past(hdr_kind) == KIND_MSG))
    |-> (accept && !unsup_req && !unexp_cpl));

  // R4
  d0_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hdr_vld) && !$past(in_d3hot)) |-> (accept && !unsup_req && !unexp_cpl));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(hdr_vld) |-> !(accept || unsup_req || unexp_cpl));

  // R5
  l0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l0_req && !link_in_l0) |=> l0_req);

  // R6
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_pend && !(err_msg_req && msg_ack)) |=> msg_pend);

  // R7
  quiet_no_rpt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_pend && !err_rpt_en) |=> !msg_pend);

  // R2
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({accept, unsup_req, unexp_cpl}));

endmodule

// File: tb/lp_req_filter_tb.sv
`timescale 1ns/1ps
module lp_req_filter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hdr_vld = 0, in_d3hot = 0, err_rpt_en = 0, cpl_chk_en = 0;
  logic link_in_l0 = 1, msg_ack = 0;
  logic [2:0] hdr_kind = 0;
  logic accept, unsup_req, unexp_cpl, l0_req, err_msg_req;

  int checks = 0, errors = 0, cyc = 0;
  bit m_acc, m_ur, m_uc, m_l0, m_pend, running = 0;
  logic [31:0] lfsr = 32'h1ace_b00c;

  always #2 clk = ~clk;

  lp_req_filter u_dut (.clk, .rst_n, .hdr_vld, .hdr_kind, .in_d3hot, .err_rpt_en,
    .cpl_chk_en, .link_in_l0, .msg_ack, .accept, .unsup_req, .unexp_cpl,
    .l0_req, .err_msg_req);

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_acc = 0; m_ur = 0; m_uc = 0; m_l0 = 0; m_pend = 0;
    end else begin
      bit ok_kind, cpl, ev, old_req;
      old_req = m_pend && link_in_l0;
      ok_kind = (hdr_kind == 3) || (hdr_kind == 4);
      cpl     = (hdr_kind == 5);
      m_ur  = hdr_vld && in_d3hot && !ok_kind && !cpl;
      m_uc  = hdr_vld && in_d3hot && cpl && cpl_chk_en;
      m_acc = hdr_vld && !m_ur && !m_uc;
      ev    = m_ur && err_rpt_en;
      if (ev && !link_in_l0) m_l0 = 1;
      else if (link_in_l0)   m_l0 = 0;
      if (ev) m_pend = 1;
      else if (old_req && msg_ack) m_pend = 0;
    end
  end

  task automatic cmp(input string tag, input logic act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) if (running) begin
    cmp("R1 R3 R4 R8 accept", accept, m_acc);
    cmp("R2 R7 unsup_req", unsup_req, m_ur);
    cmp("R3 unexp_cpl", unexp_cpl, m_uc);
    cmp("R5 R7 l0_req", l0_req, m_l0);
    cmp("R6 R7 err_msg_req", err_msg_req, m_pend && link_in_l0);
  end

  task automatic step(input bit v, input logic [2:0] k);
    @(posedge clk); #1;
    hdr_vld = v; hdr_kind = k;
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp("R9 accept", accept, 0);   cmp("R9 unsup_req", unsup_req, 0);
    cmp("R9 unexp_cpl", unexp_cpl, 0); cmp("R9 l0_req", l0_req, 0);
    cmp("R9 err_msg_req", err_msg_req, 0);
    @(posedge clk); #1 rst_n = 1; running = 1;
    // R4: every kind outside D3hot
    for (int k = 0; k < 8; k++) step(1, 3'(k));
    step(0, 0);
    // R1 R2 R3: every kind in D3hot, both completion modes, reporting off (R7)
    in_d3hot = 1;
    for (int c = 0; c < 2; c++) begin
      cpl_chk_en = c[0];
      for (int k = 0; k < 8; k++) step(1, 3'(k));
    end
    step(0, 0); step(0, 0);
    // R5 R6: error while link out of L0
    err_rpt_en = 1; link_in_l0 = 0;
    step(1, 0); step(0, 0);
    repeat (5) step(0, 0);
    link_in_l0 = 1;
    repeat (3) step(0, 0);
    msg_ack = 1; step(0, 0); msg_ack = 0;
    repeat (3) step(0, 0);
    // R5: error with link already in L0
    step(1, 6); step(0, 0); msg_ack = 1; step(0, 0); msg_ack = 0; step(0, 0);
    // mixed random phase
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk); #1;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      hdr_vld    = lfsr[0] | lfsr[9];
      hdr_kind   = lfsr[6:4];
      in_d3hot   = lfsr[12] | lfsr[13];
      err_rpt_en = lfsr[15] | lfsr[16];
      cpl_chk_en = lfsr[18];
      link_in_l0 = lfsr[20] & lfsr[22];
      msg_ack    = lfsr[25] & lfsr[27];
    end
    step(0, 0); step(0, 0);
    running = 0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule